// File: doc/BRIEF.md
# E1 Receive Frame Offsetter

This block sits between a recovered E1 receive stream and the system backplane. The incoming serial data has its own frame boundary. The backplane has its own framing pulse. The block lines the two up so that each outgoing frame begins a programmed distance after the backplane pulse. That distance has two parts: a count of whole 8-bit timeslots and a count of single bits. A signaling stream travels through the same path as the data and therefore never slips against it.

Received bits are written into a circular buffer, indexed by their position within the incoming frame. Output bits are read back by their position within the outgoing frame. That outgoing position is counted from the backplane pulse, less the programmed delay. Two frame lengths are supported: a single-stream frame of 256 bits, and a multiplexed frame of 1024 bits. The backplane clock can run at the bit rate. It can also run at twice the bit rate, and in that case a select bit picks which of the two clock edges inside a bit period updates the outputs.

Top module: `e1rx_frame_offsetter`

## Requirements
- R1: While reset is held, out_data, out_sig and out_frame are all 0.
- R2: The delay D in bit periods is 8*cfg_ts_off + cfg_bit_off. out_frame is 1 for exactly the bit period that lies D bit periods after the bit period in which bp_fp is sampled 1. With one bit per clock, it is visible after the clock edge that ends that bit period.
- R3: The frame length L is 256 bits when cfg_mux=0 and 1024 bits when cfg_mux=1. Input positions count from 0 at the bit in which in_fs is 1. Output position p is (bits since bp_fp - D) mod L. out_data for position p is the most recently stored input bit at position p. If that position is being written in the same bit period, the previous frame's bit is output.
- R4: When cfg_mux=0, a cfg_ts_off value of 32 or more acts as 31.
- R5: When cfg_mux=1, the full cfg_ts_off range 0..127 applies. The largest delay is therefore 1023 bits.
- R6: When cfg_master, cfg_ohd, cfg_smfs and cfg_cmfs are all 1, both offsets act as 0. If any one of them is 0, the programmed offsets apply.
- R7: out_sig for output position p is the in_sig value stored at input position p, so it carries the same delay as out_data.
- R8: When cfg_clk_mode=0, one bit passes per clock, the outputs update on every clock, and cfg_edge has no effect.
- R9: When cfg_clk_mode=1, a bit period is two clocks, and the first of the two is the clock in which bp_fp is 1. With cfg_edge=0, the outputs update at the edge that ends the first clock. With cfg_edge=1, they update one clock later, at the edge that ends the second clock. The outputs hold at the other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 1 | Received serial data bit |
| in_sig | input | 1 | Received signaling bit |
| in_fs | input | 1 | Marks bit 0 of the incoming frame |
| bp_fp | input | 1 | Backplane framing pulse |
| cfg_ts_off | input | 7 | Timeslot offset |
| cfg_bit_off | input | 3 | Bit offset |
| cfg_edge | input | 1 | 0: first edge updates, 1: second edge updates |
| cfg_clk_mode | input | 1 | 1: clock runs at twice the bit rate |
| cfg_mux | input | 1 | 1: 1024-bit multiplexed frame |
| cfg_master | input | 1 | Receive master mode |
| cfg_ohd | input | 1 | Overhead indication control |
| cfg_smfs | input | 1 | Signaling multiframe sync control |
| cfg_cmfs | input | 1 | CRC multiframe sync control |
| out_data | output | 1 | Offset data bit |
| out_sig | output | 1 | Offset signaling bit |
| out_frame | output | 1 | Marks bit 0 of timeslot 0 of the output frame |

## Verification
The buffer write and the buffer read can target the same position in the same bit period. This happens whenever the delay is zero and the incoming frame start coincides with the backplane pulse, either because both offsets are programmed to 0 or because the forcing controls zero them. The bench drives in_fs and bp_fp in the same bit and runs these zero-delay configurations. It then expects every output bit to be the one received a full frame earlier at that position, and never the bit arriving in the same period.

// File: rtl/e1rx_off_pkg.sv
`timescale 1ns/1ps
package e1rx_off_pkg;
  // lanes stored side by side in the alignment buffer
  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_DAT = 0;
  localparam int unsigned LANE_SIG = 1;

  typedef struct packed {
    logic frame;
    logic sig;
    logic data;
  } obit_t;
endpackage

// File: rtl/e1rx_off_calc.sv
`timescale 1ns/1ps
// Effective delay in bit periods: timeslots shifted up by the bit field width.
module e1rx_off_calc #(
  parameter int unsigned TS_W         = 7,
  parameter int unsigned BIT_W        = 3,
  parameter int unsigned NONMUX_SLOTS = 32,
  localparam int unsigned PTR_W       = TS_W + BIT_W
) (
  input  logic [TS_W-1:0]  ts_off,
  input  logic [BIT_W-1:0] bit_off,
  input  logic             mux,
  input  logic             master,
  input  logic             ohd,
  input  logic             smfs,
  input  logic             cmfs,
  output logic [PTR_W-1:0] delay
);
  localparam logic [TS_W-1:0] TS_LIMIT = TS_W'(NONMUX_SLOTS - 1);

  logic            force_zero;
  logic [TS_W-1:0] ts_eff;

  always_comb begin
    force_zero = master & ohd & smfs & cmfs;
    if (!mux && (ts_off > TS_LIMIT)) ts_eff = TS_LIMIT;
    else                             ts_eff = ts_off;
    if (force_zero) delay = '0;
    else            delay = {ts_eff, bit_off};
  end
endmodule

// File: rtl/e1rx_off_timing.sv
`timescale 1ns/1ps
// Bit phase and frame position counters for the write and read sides.
module e1rx_off_timing #(
  parameter int unsigned PTR_W       = 10,
  parameter int unsigned NONMUX_BITS = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_mode,
  input  logic             mux,
  input  logic             fp,
  input  logic             fs,
  input  logic [PTR_W-1:0] delay,
  output logic             bit_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx
);
  localparam logic [PTR_W-1:0] NONMUX_MASK = PTR_W'(NONMUX_BITS - 1);

  logic             ph_q, ph_d, cur_ph;
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [PTR_W-1:0] rd_cur, wr_cur, mask;

  always_comb begin
    cur_ph = clk_mode & ~fp & ph_q;
    bit_en = ~cur_ph;
    ph_d   = clk_mode & ~cur_ph;
    mask   = mux ? '1 : NONMUX_MASK;
    rd_cur = fp ? '0 : rd_q;
    wr_cur = fs ? '0 : wr_q;
    rd_d   = (rd_cur + PTR_W'(1)) & mask;
    wr_d   = (wr_cur + PTR_W'(1)) & mask;
    rd_idx = (rd_cur - delay) & mask;
    wr_idx = wr_cur & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (bit_en) begin
        rd_q <= rd_d;
        wr_q <= wr_d;
      end
    end
  end
endmodule

// File: rtl/e1rx_off_buf.sv
`timescale 1ns/1ps
// Circular alignment buffer, one storage array per lane.
module e1rx_off_buf #(
  parameter int unsigned PTR_W = 10,
  parameter int unsigned LANES = 2,
  localparam int unsigned DEPTH = 1 << PTR_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [LANES-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [LANES-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata[g];
    end

    assign rdata[g] = mem[raddr];
  end
endmodule

// File: rtl/e1rx_frame_offsetter.sv
`timescale 1ns/1ps
module e1rx_frame_offsetter
  import e1rx_off_pkg::*;
#(
  parameter int unsigned TS_W         = 7,
  parameter int unsigned BIT_W        = 3,
  parameter int unsigned NONMUX_SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_data,
  input  logic             in_sig,
  input  logic             in_fs,
  input  logic             bp_fp,
  input  logic [TS_W-1:0]  cfg_ts_off,
  input  logic [BIT_W-1:0] cfg_bit_off,
  input  logic             cfg_edge,
  input  logic             cfg_clk_mode,
  input  logic             cfg_mux,
  input  logic             cfg_master,
  input  logic             cfg_ohd,
  input  logic             cfg_smfs,
  input  logic             cfg_cmfs,
  output logic             out_data,
  output logic             out_sig,
  output logic             out_frame
);
  localparam int unsigned PTR_W       = TS_W + BIT_W;
  localparam int unsigned NONMUX_BITS = NONMUX_SLOTS << BIT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [PTR_W-1:0] delay, wr_idx, rd_idx;
  logic             bit_en;
  logic [LANES-1:0] wdata, rdata;

  e1rx_off_calc #(
    .TS_W(TS_W), .BIT_W(BIT_W), .NONMUX_SLOTS(NONMUX_SLOTS)
  ) u_calc (
    .ts_off(cfg_ts_off), .bit_off(cfg_bit_off), .mux(cfg_mux),
    .master(cfg_master), .ohd(cfg_ohd), .smfs(cfg_smfs), .cmfs(cfg_cmfs),
    .delay(delay)
  );

  e1rx_off_timing #(
    .PTR_W(PTR_W), .NONMUX_BITS(NONMUX_BITS)
  ) u_timing (
    .clk(clk), .rst_n(rst_sync_n), .clk_mode(cfg_clk_mode), .mux(cfg_mux),
    .fp(bp_fp), .fs(in_fs), .delay(delay),
    .bit_en(bit_en), .wr_idx(wr_idx), .rd_idx(rd_idx)
  );

  always_comb begin
    wdata           = '0;
    wdata[LANE_DAT] = in_data;
    wdata[LANE_SIG] = in_sig;
  end

  e1rx_off_buf #(
    .PTR_W(PTR_W), .LANES(LANES)
  ) u_buf (
    .clk(clk), .we(bit_en), .waddr(wr_idx), .wdata(wdata),
    .raddr(rd_idx), .rdata(rdata)
  );

  // output stage: direct load on the first edge, staged load on the second
  obit_t rd_word, stage_q, stage_d, out_q, out_d;
  logic  second_edge;

  always_comb begin
    rd_word.data  = rdata[LANE_DAT];
    rd_word.sig   = rdata[LANE_SIG];
    rd_word.frame = (rd_idx == '0);
    second_edge   = cfg_clk_mode & cfg_edge;
    stage_d       = bit_en ? rd_word : stage_q;
    if (second_edge) out_d = bit_en ? out_q : stage_q;
    else             out_d = bit_en ? rd_word : out_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      stage_q <= stage_d;
      out_q   <= out_d;
    end
  end

  assign out_data  = out_q.data;
  assign out_sig   = out_q.sig;
  assign out_frame = out_q.frame;
endmodule

// File: rtl/e1rx_off_chk.sv
`timescale 1ns/1ps
module e1rx_off_chk #(
  parameter int unsigned TS_W  = 7,
  parameter int unsigned BIT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bp_fp,
  input logic [TS_W-1:0]  cfg_ts_off,
  input logic [BIT_W-1:0] cfg_bit_off,
  input logic             cfg_edge,
  input logic             cfg_clk_mode,
  input logic             cfg_master,
  input logic             cfg_ohd,
  input logic             cfg_smfs,
  input logic             cfg_cmfs,
  input logic             bit_en,
  input logic             out_data,
  input logic             out_sig,
  input logic             out_frame
);
  logic forced;
  assign forced = cfg_master & cfg_ohd & cfg_smfs & cfg_cmfs;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!out_data && !out_sig && !out_frame)); // R1

  AST_ZERO_DELAY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_fp && !cfg_clk_mode && cfg_ts_off == '0 && cfg_bit_off == '0)
    |=> out_frame); // R2

  AST_FORCED_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_fp && !cfg_clk_mode && forced) |=> out_frame); // R6

  AST_FIRST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_mode && !cfg_edge && !bit_en)
    |=> $stable({out_data, out_sig, out_frame})); // R9

  AST_SECOND_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk_mode && cfg_edge && bit_en)
    |=> $stable({out_data, out_sig, out_frame})); // R9
endmodule

bind e1rx_frame_offsetter e1rx_off_chk #(.TS_W(TS_W), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bp_fp(bp_fp),
  .cfg_ts_off(cfg_ts_off), .cfg_bit_off(cfg_bit_off), .cfg_edge(cfg_edge),
  .cfg_clk_mode(cfg_clk_mode), .cfg_master(cfg_master), .cfg_ohd(cfg_ohd),
  .cfg_smfs(cfg_smfs), .cfg_cmfs(cfg_cmfs), .bit_en(bit_en),
  .out_data(out_data), .out_sig(out_sig), .out_frame(out_frame)
);

// File: tb/e1rx_frame_offsetter_test.sv
`timescale 1ns/1ps
module e1rx_frame_offsetter_test;
  logic       clk;
  logic       rst_n;
  logic       in_data, in_sig, in_fs, bp_fp;
  logic [6:0] cfg_ts_off;
  logic [2:0] cfg_bit_off;
  logic       cfg_edge, cfg_clk_mode, cfg_mux;
  logic       cfg_master, cfg_ohd, cfg_smfs, cfg_cmfs;
  logic       out_data, out_sig, out_frame;

  int n_chk;
  int n_fail;
  logic [15:0] lfsr;
  logic model_d [1024];
  logic model_s [1024];

  e1rx_frame_offsetter uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sig(in_sig),
    .in_fs(in_fs), .bp_fp(bp_fp), .cfg_ts_off(cfg_ts_off),
    .cfg_bit_off(cfg_bit_off), .cfg_edge(cfg_edge),
    .cfg_clk_mode(cfg_clk_mode), .cfg_mux(cfg_mux),
    .cfg_master(cfg_master), .cfg_ohd(cfg_ohd), .cfg_smfs(cfg_smfs),
    .cfg_cmfs(cfg_cmfs), .out_data(out_data), .out_sig(out_sig),
    .out_frame(out_frame)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input logic ed,
                         input logic es, input logic ef);
    chk(req, "out_data", out_data, ed);
    chk(req, "out_sig", out_sig, es);
    chk(req, "out_frame", out_frame, ef);
  endtask

  // Runs nf frames under one configuration. The incoming frame start and the
  // backplane pulse share bit 0. Frame 0 only fills the buffer.
  task automatic run_cfg(input string req, input int ts, input int bo,
                         input bit mux, input bit cm, input bit edge_sel,
                         input bit ma, input bit oh, input bit sm,
                         input bit cf, input int nf);
    int L, tse, D, p;
    logic ed, es, ef, pd, ps, pf;
    L   = mux ? 1024 : 256;
    tse = mux ? ts : ((ts > 31) ? 31 : ts);
    D   = (ma && oh && sm && cf) ? 0 : tse * 8 + bo;
    cfg_ts_off = 7'(ts); cfg_bit_off = 3'(bo); cfg_mux = mux;
    cfg_clk_mode = cm; cfg_edge = edge_sel;
    cfg_master = ma; cfg_ohd = oh; cfg_smfs = sm; cfg_cmfs = cf;
    pd = 1'b0; ps = 1'b0; pf = 1'b0;
    for (int f = 0; f < nf; f++) begin
      for (int b = 0; b < L; b++) begin
        in_fs = (b == 0);
        bp_fp = (b == 0);
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        in_data = lfsr[0];
        if (b % 8 == 0) in_sig = lfsr[5];
        p  = ((b - D) % L + L) % L;
        ed = model_d[p]; es = model_s[p]; ef = (p == 0);
        model_d[b] = in_data;
        model_s[b] = in_sig;
        @(posedge clk); #1;
        if (!cm) begin
          if (f > 0) chk_out(req, ed, es, ef);
        end else begin
          if (f > 0) begin
            if (!edge_sel) chk_out(req, ed, es, ef);   // R9 first edge
            else           chk_out(req, pd, ps, pf);   // R9 held until second
          end
          in_fs = 1'b0;
          bp_fp = 1'b0;
          @(posedge clk); #1;
          if (f > 0) chk_out(req, ed, es, ef);
        end
        pd = ed; ps = es; pf = ef;
      end
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    in_data = 1'b0; in_sig = 1'b0; in_fs = 1'b0; bp_fp = 1'b0;
    cfg_ts_off = '0; cfg_bit_off = '0; cfg_edge = 1'b0; cfg_clk_mode = 1'b0;
    cfg_mux = 1'b0; cfg_master = 1'b0; cfg_ohd = 1'b0; cfg_smfs = 1'b0;
    cfg_cmfs = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk_out("R1", 1'b0, 1'b0, 1'b0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // read and write hit the same position in every bit period
  task automatic test_zero_offset;
    run_cfg("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
  endtask

  task automatic test_slot_bit_offset;
    run_cfg("R2", 5, 3, 0, 0, 0, 0, 0, 0, 0, 3);
  endtask

  task automatic test_largest_nonmux;
    run_cfg("R2", 31, 7, 0, 0, 0, 0, 0, 0, 0, 3);
  endtask

  task automatic test_clamp;
    run_cfg("R4", 100, 2, 0, 0, 0, 0, 0, 0, 0, 3);
  endtask

  task automatic test_mux_offset;
    run_cfg("R5", 100, 7, 1, 0, 0, 0, 0, 0, 0, 2);
  endtask

  task automatic test_mux_largest;
    run_cfg("R5", 127, 7, 1, 0, 0, 0, 0, 0, 0, 2);
  endtask

  task automatic test_forced_zero;
    run_cfg("R6", 9, 5, 0, 0, 0, 1, 1, 1, 1, 3);
  endtask

  task automatic test_partial_force;
    run_cfg("R6", 9, 5, 0, 0, 0, 1, 1, 1, 0, 3);
  endtask

  // signaling changes per timeslot while the offset crosses a slot boundary
  task automatic test_sig_align;
    run_cfg("R7", 3, 6, 0, 0, 0, 0, 0, 0, 0, 3);
  endtask

  task automatic test_edge_ignored;
    run_cfg("R8", 3, 1, 0, 0, 1, 0, 0, 0, 0, 3);
  endtask

  task automatic test_first_edge;
    run_cfg("R9", 2, 6, 0, 1, 0, 0, 0, 0, 0, 3);
  endtask

  task automatic test_second_edge;
    run_cfg("R9", 2, 6, 0, 1, 1, 0, 0, 0, 0, 3);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    lfsr = 16'hACE1;
    test_reset();
    test_zero_offset();
    test_slot_bit_offset();
    test_largest_nonmux();
    test_clamp();
    test_mux_offset();
    test_mux_largest();
    test_forced_zero();
    test_partial_force();
    test_sig_align();
    test_edge_ignored();
    test_first_edge();
    test_second_edge();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule